// File: doc/BRIEF.md
# Bidirectional Reset Source Classifier

This block sits on the processor side of a shared, active-low open-drain reset line. Either an internal fault source raises a request, or another device pulls the line low. In both cases the block drives the line low itself for a fixed number of bus-clock cycles. It then lets the line go and waits a fixed settle time. After that it reads the line through a two-flop synchronizer.

If the line has returned high by then, the block concludes that it started the reset itself. It reports the alternate vector so that saved cause information can be used. If the line is still low, some other agent is holding it or the line rose too slowly. The block then waits for the synchronized line to go high, reports the normal vector and flags that saved state must be thrown away.

Each sequence ends with a one-cycle report strobe that carries the vector select and discard flags. The result therefore depends on how quickly the board pulls the line up: a line that is still low at the fixed sample point is treated as an external reset.

The state machine uses six states:
- **IDLE**: waiting for a cause.
- **DRIVE**: the line is driven low.
- **SETTLE**: the line is released and the block waits.
- **SAMPLE**: the synchronized line is read.
- **HOLD**: waiting for an external holder to let go.
- **REPORT**: the strobe cycle.

The transitions are:
- **START**: IDLE to DRIVE, on a request or a low line.
- **DRIVE_DONE**: DRIVE to SETTLE.
- **SETTLE_DONE**: SETTLE to SAMPLE.
- **SEEN_HIGH**: SAMPLE to REPORT.
- **SEEN_LOW**: SAMPLE to HOLD.
- **LINE_UP**: HOLD to REPORT.
- **FINISH**: REPORT to IDLE.

Top module: `rstsrc_classifier`

## Requirements
- R1: A request (`int_req` high) seen at a clock edge while idle makes `line_drive` high in the following cycle, for exactly DRIVE_CYC (default 4) consecutive cycles.
- R2: After release, the block waits WAIT_CYC (default 2) cycles and then spends one cycle reading the pin level delayed by two synchronizer flops. With an instantly rising line, `done` is high in the 8th cycle after the request edge.
- R3: If the sampled level is high (1), `done` pulses with `vec_alt` = 1 (alternate vector) and `discard` = 0.
- R4: If the sampled level is low (0), the block waits until the synchronized pin is high and then pulses `done` with `vec_alt` = 0 (normal vector) and `discard` = 1. `done` appears in the 3rd cycle after the pin goes high. A line that rises one or more cycles after release is classified this way.
- R5: A low pin seen while idle, with no request, starts the same drive, settle and sample sequence after two cycles of synchronizer delay. If the other agent lets go early enough, the sample reads high.
- R6: `done` is high for exactly one cycle per sequence, with `vec_alt` and `discard` exactly one of them high. Both are 0 whenever `done` is 0, and `line_drive` is 0 while `done` is high.
- R7: Requests made while a sequence runs, including during the report cycle, are ignored: each sequence gives one `done` and one drive burst.
- R8: While `rst_n` is low, `line_drive`, `done`, `vec_alt` and `discard` are 0. The synchronizer resets to a high level, so a high pin after reset starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req | input | 1 | Internal reset cause (watchdog, clock fault) |
| pin_in | input | 1 | Level read back from the shared reset line |
| line_drive | output | 1 | 1 = pull the shared line low |
| done | output | 1 | One-cycle end-of-sequence strobe |
| vec_alt | output | 1 | With `done`: 1 = alternate vector, 0 = normal vector |
| discard | output | 1 | With `done`: 1 = saved state must be erased |

## Verification
A wrong state or counter value shows up at `line_drive` within one cycle. The drive burst comes out longer or shorter than four cycles, or a burst appears without a cause. A wrong classification shows at the `done` strobe as a swapped `vec_alt`/`discard` pair.

A wrong count in the settle phase moves the sample point. That becomes visible as a shifted strobe cycle, or, on lines that rise with a lag of one cycle or pulses of seven versus eight cycles, as a flipped classification. A HOLD state that fails to wait shows up as a strobe earlier than three cycles after the line is let go.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRIVE  = 3'd1,
        ST_SETTLE = 3'd2,
        ST_SAMPLE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_REPORT = 3'd5
    } rsc_state_e;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/rsc_timer.sv
module rsc_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            count <= '0;
        else if (clr)          count <= '0;
        else if (count != TOP) count <= count + 1'b1;
    end

endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
    import rstsrc_pkg::*;
#(
    parameter int DRIVE_CYC = 4,
    parameter int WAIT_CYC  = 2,
    parameter int CW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          int_req,
    input  logic          pin_sync,
    input  logic [CW-1:0] tick,
    output logic          tmr_clr,
    output logic          line_drive,
    output logic          done,
    output logic          vec_alt,
    output logic          discard
);

    localparam logic [CW-1:0] DRIVE_LAST = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] WAIT_LAST  = CW'(WAIT_CYC - 1);

    rsc_state_e state_q, state_d;
    logic       ext_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (int_req || !pin_sync) state_d = ST_DRIVE;   // START
            ST_DRIVE:  if (tick == DRIVE_LAST)   state_d = ST_SETTLE;  // DRIVE_DONE
            ST_SETTLE: if (tick == WAIT_LAST)    state_d = ST_SAMPLE;  // SETTLE_DONE
            ST_SAMPLE: state_d = pin_sync ? ST_REPORT : ST_HOLD;       // SEEN_HIGH / SEEN_LOW
            ST_HOLD:   if (pin_sync)             state_d = ST_REPORT;  // LINE_UP
            ST_REPORT: state_d = ST_IDLE;                              // FINISH
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Classification flag captured at the sample point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     ext_q <= 1'b0;
        else if (state_q == ST_SAMPLE)  ext_q <= !pin_sync;
    end

    // Outputs
    always_comb begin
        line_drive = (state_q == ST_DRIVE);
        done       = (state_q == ST_REPORT);
        vec_alt    = (state_q == ST_REPORT) && !ext_q;
        discard    = (state_q == ST_REPORT) && ext_q;
        tmr_clr    = (state_d != state_q);
    end

endmodule

// File: rtl/rstsrc_classifier.sv
module rstsrc_classifier #(
    parameter int DRIVE_CYC   = 4,
    parameter int WAIT_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_req,
    input  logic pin_in,
    output logic line_drive,
    output logic done,
    output logic vec_alt,
    output logic discard
);

    localparam int MAXC = (DRIVE_CYC > WAIT_CYC) ? DRIVE_CYC : WAIT_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    logic          pin_sync;
    logic          tmr_clr;
    logic [CW-1:0] tick;

    rsc_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (pin_in),
        .q_out(pin_sync)
    );

    rsc_timer #(
        .CW(CW)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .count(tick)
    );

    rsc_fsm #(
        .DRIVE_CYC(DRIVE_CYC),
        .WAIT_CYC (WAIT_CYC),
        .CW       (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_req   (int_req),
        .pin_sync  (pin_sync),
        .tick      (tick),
        .tmr_clr   (tmr_clr),
        .line_drive(line_drive),
        .done      (done),
        .vec_alt   (vec_alt),
        .discard   (discard)
    );

endmodule

// File: rtl/rstsrc_classifier_chk.sv
module rstsrc_classifier_chk #(
    parameter int DRIVE_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic line_drive,
    input logic done,
    input logic vec_alt,
    input logic discard
);

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_q <= 0;
        else if (line_drive) run_q <= run_q + 1;
        else                 run_q <= 0;
    end

    // R1: a drive burst lasts exactly DRIVE_CYC cycles
    p_drive_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_drive && run_q < DRIVE_CYC - 1) |=> line_drive);
    p_drive_long_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (line_drive && run_q >= DRIVE_CYC - 1) |=> !line_drive);

    // R6: strobe lasts one cycle
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: flags only with the strobe
    p_flags_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!vec_alt && !discard));
    // R3 / R4: exactly one classification per strobe
    p_one_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vec_alt != discard));
    // R6: line released while reporting
    p_no_drive_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !line_drive);
    // R2: strobe never directly follows a drive cycle
    p_settle_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_drive |=> !done);

endmodule

bind rstsrc_classifier rstsrc_classifier_chk #(
    .DRIVE_CYC(DRIVE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_drive(line_drive),
    .done      (done),
    .vec_alt   (vec_alt),
    .discard   (discard)
);

// File: tb/test_rstsrc_classifier.sv
module test_rstsrc_classifier;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_req = 1'b0;
    logic ext_low = 1'b0;
    int   lag_sel = 0;
    int   lag_cnt = 0;
    logic pin_in;
    logic line_drive, done, vec_alt, discard;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Line model: driven low by the block, by another agent, or still rising
    always_ff @(posedge clk) begin
        if (line_drive)       lag_cnt <= lag_sel;
        else if (lag_cnt > 0) lag_cnt <= lag_cnt - 1;
    end
    assign pin_in = !(line_drive || ext_low || (lag_cnt != 0));

    rstsrc_classifier i_rstsrc_classifier (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_req   (int_req),
        .pin_in    (pin_in),
        .line_drive(line_drive),
        .done      (done),
        .vec_alt   (vec_alt),
        .discard   (discard)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Columns: internal?, external hold cycles, rise lag, exp alt, exp discard, exp latency
    localparam int NV = 7;
    localparam int TBL [NV][6] = '{
        '{1,  0, 0, 1, 0,  8},   // R3 fast line
        '{1,  0, 1, 0, 1,  9},   // R4 one-cycle lag
        '{1,  0, 3, 0, 1, 11},   // R4 three-cycle lag
        '{0,  2, 0, 1, 0, 10},   // R5 short external pulse
        '{0,  7, 0, 1, 0, 10},   // R5 released just in time
        '{0,  8, 0, 0, 1, 11},   // R5 still low at sample
        '{0, 30, 0, 0, 1, 33}    // R4 long external hold
    };

    int drv, dn, lat, got_alt, got_disc;

    task automatic run_seq(input bit is_int, input int ext_cyc, input int extra_req_at,
                           input int cycles);
        drv = 0; dn = 0; lat = 0; got_alt = 0; got_disc = 0;
        @(negedge clk);
        if (is_int) int_req = 1'b1; else ext_low = 1'b1;
        for (int k = 1; k <= cycles; k++) begin
            @(negedge clk);
            int_req = (k == extra_req_at);
            if (!is_int && k == ext_cyc) ext_low = 1'b0;
            if (line_drive) drv++;
            if (done) begin
                dn++;
                if (dn == 1) begin
                    lat = k; got_alt = vec_alt; got_disc = discard;
                end
            end
        end
        int_req = 1'b0;
        ext_low = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk(!line_drive && !done && !vec_alt && !discard, "R8 reset outputs",
            {line_drive, done, vec_alt, discard}, 0);
        rst_n = 1'b1;
        drv = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (line_drive || done) drv++;
        end
        chk(drv == 0, "R8 idle after reset", drv, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            lag_sel = TBL[v][2];
            run_seq(TBL[v][0] != 0, TBL[v][1], -1, 45);
            chk(drv == 4, "R1 drive length", drv, 4);
            chk(dn == 1, "R6 one strobe", dn, 1);
            chk(lat == TBL[v][5], TBL[v][0] != 0 ? "R2 strobe cycle" : "R5 strobe cycle",
                lat, TBL[v][5]);
            chk(got_alt == TBL[v][3], TBL[v][3] != 0 ? "R3 vec_alt" : "R4 vec_alt",
                got_alt, TBL[v][3]);
            chk(got_disc == TBL[v][4], TBL[v][4] != 0 ? "R4 discard" : "R3 discard",
                got_disc, TBL[v][4]);
            lag_sel = 0;
            repeat (5) @(negedge clk);
        end

        // R7: request mid-drive ignored
        run_seq(1'b1, 0, 3, 40);
        chk(dn == 1, "R7 mid-drive request strobes", dn, 1);
        chk(drv == 4, "R7 mid-drive request drive", drv, 4);

        // R7: request during report cycle ignored
        run_seq(1'b1, 0, 8, 40);
        chk(dn == 1, "R7 report-cycle request strobes", dn, 1);
        chk(drv == 4, "R7 report-cycle request drive", drv, 4);

        // R8: reset in the middle of a drive burst
        @(negedge clk);
        int_req = 1'b1;
        @(negedge clk);
        int_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!line_drive && !done, "R8 reset mid-drive", {line_drive, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        drv = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (line_drive || done) drv++;
        end
        chk(drv == 0, "R8 no restart after reset", drv, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule